// File: doc/BRIEF.md
# Four-Way Translation Lookaside Buffer with Global Entries

This block holds recently used translations from virtual page numbers to physical page numbers for 4 KB pages. It is organised as a set-associative array of four ways. A lookup splits the incoming page number into a set index, taken from its low bits, and a tag, taken from the upper bits. All four ways of the selected set are compared at once, and the matching way drives the physical page number and its permission bits (writable, user, dirty) out in the same cycle. On a miss, the surrounding core walks the page tables and then writes the result back through the fill port.

Two kinds of invalidation exist. A per-page invalidate removes the one entry that matches a given page number, whatever its global marking. A flush, issued when the page-table base register is reloaded, clears every entry that is not marked global. Global entries therefore survive context switches and can only be removed by the per-page invalidate.

When a set is full, the fill chooses a victim using a three-bit tree pseudo-LRU per set. Both lookup hits and fills mark their way as most recently used. The set count is a parameter. The default is 32 sets, which gives 128 entries.

Top module: `tlb_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: A lookup that matches a valid entry asserts `lk_hit` in the same cycle and returns the stored page number and the writable, user and dirty bits. On a miss, `lk_ppn` and all three permission outputs are zero.
- R3: The set index is `lk_vpn[IDX_W-1:0]` (5 bits by default) and the tag is the remaining upper bits. A page number with the same index but a different tag misses.
- R4: A lookup in the same cycle as a fill of a page number not yet held reports a miss. The new entry hits from the following cycle on.
- R5: A flush clears every entry whose global bit is zero.
- R6: A flush leaves entries whose global bit is one valid and unchanged.
- R7: A per-page invalidate clears the entry matching `inv_vpn` even when it is global, and leaves the other ways of the set in place.
- R8: A fill into a set with an invalid way writes the lowest-numbered invalid way and evicts nothing.
- R9: A fill into a full set evicts the way chosen by the set's tree pseudo-LRU. The root bit selects the pair of ways {0,1} when it is 0 and the pair {2,3} when it is 1. Each leaf bit selects the lower way of its pair when it is 0. A hit or a fill points all bits on its path away from the way it used.
- R10: A fill of a page number that is already present overwrites that entry in place and creates no duplicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_ppn | output | PPN_W | Physical page number (zero on miss) |
| lk_wr | output | 1 | Page writable |
| lk_user | output | 1 | Page accessible at user level |
| lk_dirty | output | 1 | Page already written |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page number of the new translation |
| fill_ppn | input | PPN_W | Physical page number of the new translation |
| fill_wr | input | 1 | Writable bit to store |
| fill_user | input | 1 | User bit to store |
| fill_dirty | input | 1 | Dirty bit to store |
| fill_global | input | 1 | Entry survives flushes |
| inv_en | input | 1 | Invalidate the single page `inv_vpn` |
| inv_vpn | input | VPN_W | Page number to invalidate |
| flush_en | input | 1 | Drop all non-global entries |

## Verification
The bench fills one set to capacity, steers the pseudo-LRU with hits, and checks which entry disappears on each further fill. A design whose tree bits point the wrong way, or that does not update on hits, would evict a recently used translation. It then refills a present page with a new frame number. A design that allocated a second way would evict a live neighbour, and could return the stale frame number. The bench flushes with both global and non-global entries resident, then invalidates the global one by page number. A design that treated the two kinds of invalidation alike would either lose the global entry on the flush or keep it after the per-page invalidate. It also looks up a page in the same cycle that it is filled, and it refills a set after a per-page invalidate has opened a hole. Forwarding the fill early would report a false hit. Ignoring the hole would evict through the pseudo-LRU.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int WAYS = 4;

    typedef struct packed {
        logic wr;
        logic usr;
        logic dirty;
    } perm_t;

    // Tree state: [0] root, [1] pair {0,1}, [2] pair {2,3}.
    // A bit value names the side holding the next victim.
    function automatic logic [2:0] plru_touch(input logic [2:0] st, input logic [1:0] way);
        logic [2:0] nx;
        nx = st;
        nx[0] = ~way[1];
        if (way[1] == 1'b0) nx[1] = ~way[0];
        else                nx[2] = ~way[0];
        return nx;
    endfunction

    function automatic logic [1:0] plru_victim(input logic [2:0] st);
        return st[0] ? {1'b1, st[2]} : {1'b0, st[1]};
    endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int TAG_W = 15,
    parameter int PPN_W = 28,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output perm_t            lk_perm,
    input  logic [IDX_W-1:0] fl_idx,
    input  logic [TAG_W-1:0] fl_tag,
    input  logic             fl_we,
    input  logic [PPN_W-1:0] fl_ppn,
    input  perm_t            fl_perm,
    input  logic             fl_glob,
    output logic             fl_vld,
    output logic             fl_match,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag,
    input  logic             flush
);

    logic [SETS-1:0]  vld;
    logic [SETS-1:0]  glob;
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [PPN_W-1:0] ppn_q  [SETS];
    perm_t            perm_q [SETS];
    logic             inv_hit;

    assign lk_hit   = vld[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_ppn   = ppn_q[lk_idx];
    assign lk_perm  = perm_q[lk_idx];
    assign fl_vld   = vld[fl_idx];
    assign fl_match = vld[fl_idx] && (tag_q[fl_idx] == fl_tag);
    assign inv_hit  = inv_en && vld[inv_idx] && (tag_q[inv_idx] == inv_tag);

    // Valid bits: a fill wins over a flush or invalidate of the same slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (fl_we && fl_idx == IDX_W'(s))
                    vld[s] <= 1'b1;
                else if ((flush && !glob[s]) || (inv_hit && inv_idx == IDX_W'(s)))
                    vld[s] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fl_we) begin
            tag_q[fl_idx]  <= fl_tag;
            ppn_q[fl_idx]  <= fl_ppn;
            perm_q[fl_idx] <= fl_perm;
            glob[fl_idx]   <= fl_glob;
        end
    end

    p_fill_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |=> vld[$past(fl_idx)]);

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        p_flush_drops_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (flush && !(fl_we && fl_idx == IDX_W'(s))) |=> (!vld[s] || glob[s]));
        p_flush_keeps_global_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flush && vld[s] && glob[s] && !(inv_hit && inv_idx == IDX_W'(s))) |=> vld[s]);
        p_inval_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (inv_hit && inv_idx == IDX_W'(s) && !(fl_we && fl_idx == IDX_W'(s))) |=> !vld[s]);
    end

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru
    import tlb_pkg::*;
#(
    parameter int SETS = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic [1:0]       hit_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [1:0]       fill_way,
    output logic [1:0]       victim
);

    logic [2:0] st [SETS];

    assign victim = plru_victim(st[fill_idx]);

    // Fill touch is applied last so it wins when both hit one set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) st[s] <= '0;
        end else begin
            if (hit_en)  st[hit_idx]  <= plru_touch(st[hit_idx], hit_way);
            if (fill_en) st[fill_idx] <= plru_touch(st[fill_idx], fill_way);
        end
    end

    p_fill_not_next_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> plru_victim(st[$past(fill_idx)]) != $past(fill_way));

    p_hit_not_next_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && !(fill_en && fill_idx == hit_idx)) |=> plru_victim(st[$past(hit_idx)]) != $past(hit_way));

endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 28,
    parameter int SETS  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_wr,
    output logic             lk_user,
    output logic             lk_dirty,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr,
    input  logic             fill_user,
    input  logic             fill_dirty,
    input  logic             fill_global,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_en
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;

    logic [IDX_W-1:0] lk_idx, fl_idx, inv_idx;
    logic [TAG_W-1:0] lk_tag, fl_tag, inv_tag;

    assign lk_idx  = lk_vpn[IDX_W-1:0];
    assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
    assign fl_idx  = fill_vpn[IDX_W-1:0];
    assign fl_tag  = fill_vpn[VPN_W-1:IDX_W];
    assign inv_idx = inv_vpn[IDX_W-1:0];
    assign inv_tag = inv_vpn[VPN_W-1:IDX_W];

    logic [WAYS-1:0]  way_hit, way_vld, way_match, way_we;
    logic [PPN_W-1:0] way_ppn  [WAYS];
    perm_t            way_perm [WAYS];
    perm_t            fl_perm;

    assign fl_perm = '{wr: fill_wr, usr: fill_user, dirty: fill_dirty};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way #(.SETS(SETS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_idx   (lk_idx),
            .lk_tag   (lk_tag),
            .lk_hit   (way_hit[w]),
            .lk_ppn   (way_ppn[w]),
            .lk_perm  (way_perm[w]),
            .fl_idx   (fl_idx),
            .fl_tag   (fl_tag),
            .fl_we    (way_we[w]),
            .fl_ppn   (fill_ppn),
            .fl_perm  (fl_perm),
            .fl_glob  (fill_global),
            .fl_vld   (way_vld[w]),
            .fl_match (way_match[w]),
            .inv_en   (inv_en),
            .inv_idx  (inv_idx),
            .inv_tag  (inv_tag),
            .flush    (flush_en)
        );
    end

    // Lookup way multiplexer
    logic [1:0] hit_way;
    perm_t      out_perm;

    always_comb begin
        lk_hit   = 1'b0;
        lk_ppn   = '0;
        out_perm = '0;
        hit_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_valid && way_hit[w]) begin
                lk_hit   = 1'b1;
                lk_ppn   = lk_ppn | way_ppn[w];
                out_perm = out_perm | way_perm[w];
                hit_way  = 2'(w);
            end
        end
    end

    assign lk_wr    = out_perm.wr;
    assign lk_user  = out_perm.usr;
    assign lk_dirty = out_perm.dirty;

    // Fill way choice: existing match, then lowest invalid, then pseudo-LRU.
    logic [1:0] plru_way, fill_way, free_way;
    logic       any_match, any_free;
    logic [1:0] match_way;

    always_comb begin
        any_match = 1'b0;
        match_way = '0;
        any_free  = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                any_match = 1'b1;
                match_way = 2'(w);
            end
            if (!way_vld[w]) begin
                any_free = 1'b1;
                free_way = 2'(w);
            end
        end
        if (any_match)     fill_way = match_way;
        else if (any_free) fill_way = free_way;
        else               fill_way = plru_way;
        way_we = '0;
        way_we[fill_way] = fill_en;
    end

    tlb_plru #(.SETS(SETS)) u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_en   (lk_hit),
        .hit_idx  (lk_idx),
        .hit_way  (hit_way),
        .fill_en  (fill_en),
        .fill_idx (fl_idx),
        .fill_way (fill_way),
        .victim   (plru_way)
    );

    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    p_no_duplicate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_match));

    p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(way_we) == (fill_en ? 1 : 0));

    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0 && !lk_wr && !lk_user && !lk_dirty));

endmodule

// File: tb/tlb_top_bench.sv
module tlb_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int VPN_W = 20;
    localparam int PPN_W = 28;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             lk_hit, lk_wr, lk_user, lk_dirty;
    logic [PPN_W-1:0] lk_ppn;
    logic             fill_en = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             fill_wr = 1'b0, fill_user = 1'b0, fill_dirty = 1'b0, fill_global = 1'b0;
    logic             inv_en = 1'b0;
    logic [VPN_W-1:0] inv_vpn = '0;
    logic             flush_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_top u_tlb_top (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_wr(lk_wr), .lk_user(lk_user), .lk_dirty(lk_dirty),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_wr(fill_wr), .fill_user(fill_user), .fill_dirty(fill_dirty), .fill_global(fill_global),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_en(flush_en)
    );

    typedef struct {
        logic             hit;
        logic [PPN_W-1:0] ppn;
        logic [2:0]       perm;
        string            req;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   errors  = 0;
    bit   done    = 1'b0;

    function automatic logic [VPN_W-1:0] mk(input int tag, input int idx);
        return {15'(tag), 5'(idx)};
    endfunction

    task automatic idle_inputs();
        lk_valid = 1'b0; fill_en = 1'b0; inv_en = 1'b0; flush_en = 1'b0; fill_global = 1'b0;
    endtask

    // Driver: one operation per cycle, inputs change at the falling edge.
    task automatic look(input logic [VPN_W-1:0] v, input bit h, input logic [PPN_W-1:0] p,
                        input logic [2:0] pm, input string r);
        exp_t e;
        @(negedge clk);
        idle_inputs();
        lk_valid = 1'b1; lk_vpn = v;
        e.hit = h; e.ppn = h ? p : '0; e.perm = h ? pm : 3'b000; e.req = r;
        q.push_back(e);
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                        input logic [2:0] pm, input bit g);
        @(negedge clk);
        idle_inputs();
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p;
        {fill_wr, fill_user, fill_dirty} = pm; fill_global = g;
    endtask

    task automatic fill_and_look(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input string r);
        exp_t e;
        @(negedge clk);
        idle_inputs();
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p; {fill_wr, fill_user, fill_dirty} = 3'b100;
        lk_valid = 1'b1; lk_vpn = v;
        e.hit = 1'b0; e.ppn = '0; e.perm = 3'b000; e.req = r;
        q.push_back(e);
    endtask

    task automatic inval(input logic [VPN_W-1:0] v);
        @(negedge clk);
        idle_inputs();
        inv_en = 1'b1; inv_vpn = v;
    endtask

    task automatic flush_all();
        @(negedge clk);
        idle_inputs();
        flush_en = 1'b1;
    endtask

    // Monitor: compares the combinational lookup result a quarter period after the inputs settle.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (lk_valid) begin
            exp_t e;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: lookup with no expectation, actual hit=%0b expected none", lk_hit);
            end else begin
                e = q.pop_front();
                vectors++;
                if (lk_hit !== e.hit || lk_ppn !== e.ppn || {lk_wr, lk_user, lk_dirty} !== e.perm) begin
                    errors++;
                    $display("FAIL %s: vpn=%h actual hit=%0b ppn=%h perm=%b expected hit=%0b ppn=%h perm=%b",
                             e.req, lk_vpn, lk_hit, lk_ppn, {lk_wr, lk_user, lk_dirty},
                             e.hit, e.ppn, e.perm);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(mk(0, 0), 0, 0, 0, "R1");
        look(mk(3, 17), 0, 0, 0, "R1");

        // R2 / R3: basic hit and index/tag split
        fill(mk('h11, 3), 28'h0ABC, 3'b101, 0);
        look(mk('h11, 3), 1, 28'h0ABC, 3'b101, "R2");
        look(mk('h12, 3), 0, 0, 0, "R3");
        look(mk('h11, 4), 0, 0, 0, "R3");

        // R4: same-cycle fill and lookup
        fill_and_look(mk('h21, 4), 28'h0222, "R4");
        look(mk('h21, 4), 1, 28'h0222, 3'b100, "R4");

        // R5 / R6 / R7: flush and single-page invalidate
        fill(mk('h31, 5), 28'h0333, 3'b011, 1);
        fill(mk('h32, 5), 28'h0334, 3'b010, 0);
        flush_all();
        look(mk('h31, 5), 1, 28'h0333, 3'b011, "R6");
        look(mk('h32, 5), 0, 0, 0, "R5");
        look(mk('h11, 3), 0, 0, 0, "R5");
        fill(mk('h33, 5), 28'h0335, 3'b001, 0);
        inval(mk('h31, 5));
        look(mk('h31, 5), 0, 0, 0, "R7");
        look(mk('h33, 5), 1, 28'h0335, 3'b001, "R7");

        // R8: a hole left by invalidate is reused before any eviction
        for (int i = 0; i < 4; i++) fill(mk('h40 + i, 7), 28'h0700 + 28'(i), 3'b100, 0);
        inval(mk('h41, 7));
        fill(mk('h4F, 7), 28'h07FF, 3'b110, 0);
        look(mk('h40, 7), 1, 28'h0700, 3'b100, "R8");
        look(mk('h42, 7), 1, 28'h0702, 3'b100, "R8");
        look(mk('h43, 7), 1, 28'h0703, 3'b100, "R8");
        look(mk('h4F, 7), 1, 28'h07FF, 3'b110, "R8");

        // R9: pseudo-LRU replacement in set 0 (A..D fill ways 0..3)
        for (int i = 0; i < 4; i++) fill(mk('h50 + i, 0), 28'h0500 + 28'(i), 3'b100, 0);
        look(mk('h50, 0), 1, 28'h0500, 3'b100, "R9");   // A touched: victim becomes way 2 (C)
        fill(mk('h5E, 0), 28'h05EE, 3'b100, 0);
        look(mk('h52, 0), 0, 0, 0, "R9");
        look(mk('h50, 0), 1, 28'h0500, 3'b100, "R9");
        look(mk('h51, 0), 1, 28'h0501, 3'b100, "R9");
        look(mk('h53, 0), 1, 28'h0503, 3'b100, "R9");
        look(mk('h5E, 0), 1, 28'h05EE, 3'b100, "R9");   // victim now way 0 (A)
        fill(mk('h5F, 0), 28'h05FF, 3'b100, 0);
        look(mk('h50, 0), 0, 0, 0, "R9");

        // R10: refill of a present page updates in place
        fill(mk('h51, 0), 28'h0ABD, 3'b111, 0);
        look(mk('h51, 0), 1, 28'h0ABD, 3'b111, "R10");
        look(mk('h5F, 0), 1, 28'h05FF, 3'b100, "R10");
        look(mk('h5E, 0), 1, 28'h05EE, 3'b100, "R10");
        look(mk('h53, 0), 1, 28'h0503, 3'b100, "R10");

        @(negedge clk);
        idle_inputs();
        repeat (2) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending, expected 0", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule